// File: doc/BRIEF.md
# Parallel Video to Stream Bridge

This block takes pixels from a parallel video source and sends them out as a valid/ready pixel stream in the AXI4-Stream video style. The source supplies a pixel bus with a pixel-valid qualifier, plus a frame synchronisation input and a line-active input. A camera that drives frame-valid and line-valid connects straight to these two inputs. A display-style source can be connected the same way, provided its line input is high (or low) across the active pixels of each line.

Frame and line boundaries come only from edges on the sync inputs. No porch, blanking or total line length is assumed, so any blanking interval is accepted. A rising frame edge arms a start-of-frame flag. The next accepted pixel carries that flag. The end of line has to be marked on the last pixel of the line, and that pixel is only known once the line input falls. For this reason each captured pixel waits in a one-deep holding stage until the next pixel or the line end decides its end-of-line bit.

Pixels leave the holding stage into a small FIFO, which absorbs backpressure from the consumer. When the FIFO is full, the pixel that would have entered it is discarded and a sticky overflow flag is raised. A parameter selects whether both sync inputs are active-high or active-low.

Top module: `vidstream_bridge`

## Requirements
- R1: While reset is held and directly after it is released, outValid is 0 and overflow is 0.
- R2: A pixel is captured only in a cycle where pixValid is 1 and the line input is at its active level. Pixels with pixValid low, or with the line input inactive, never appear on the output. Captured pixels leave in the order they arrived.
- R3: When the line input leaves its active level, the last pixel captured during that line is output with outEol = 1. Every other pixel has outEol = 0. A line with no captured pixels produces no output.
- R4: A transition of the frame input to its active level arms a start flag. The first pixel captured afterwards, including one captured in the same cycle as the transition, carries outSof = 1. All other pixels carry outSof = 0.
- R5: Any number of idle cycles between lines or frames is accepted. The level of the frame input never gates capture; only its activating edge matters.
- R6: A captured pixel is not offered on the output until the next pixel is captured or its line ends. While outValid is 1 and outReady is 0, outValid, outData, outSof and outEol hold their values.
- R7: The FIFO holds FIFO_DEPTH pixels. A pixel leaving the holding stage while the FIFO already holds FIFO_DEPTH entries is discarded, and overflow goes to 1 and stays at 1 until reset.
- R8: With SYNC_ACTIVE_LOW = 1, both sync inputs are active when low. Fed the inverted sync signals, the block behaves exactly as the active-high build does.
- R9: When the FIFO is empty, outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixData | input | DATA_W | Parallel pixel value |
| pixValid | input | 1 | Pixel qualifier |
| frameSync | input | 1 | Frame-valid or vertical sync; activating edge starts a frame |
| lineSync | input | 1 | Line-valid level; leaving the active level ends a line |
| outData | output | DATA_W | Stream pixel data |
| outValid | output | 1 | Stream valid |
| outReady | input | 1 | Stream ready from the consumer |
| outSof | output | 1 | Start-of-frame marker (user bit) |
| outEol | output | 1 | End-of-line marker (last bit) |
| overflow | output | 1 | Sticky flag: a pixel was discarded on a full FIFO |

## Verification
The main bench instance uses DATA_W = 8 and FIFO_DEPTH = 4, with active-high syncs. At that depth a single stalled line of six pixels fills the FIFO and then forces two discards, so both the overflow path and its sticky flag can be reached. A second copy built with SYNC_ACTIVE_LOW = 1 receives the inverted syncs alongside the first, and its outputs are compared with the active-high copy on every cycle. The stimulus table mixes blanking gaps of different lengths, a pixel outside a line, an empty line, and a frame edge that coincides with a pixel.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic loadHold;  // capture pixData into the holding stage
    logic holdSof;   // start-of-frame bit for the pixel being captured
    logic pushHold;  // move the held pixel into the FIFO
    logic pushEol;   // the pixel being moved ends its line
  } vsbStrobes_t;

endpackage

// File: rtl/vsb_ctrl.sv
module vsb_ctrl
  import vsb_pkg::*;
#(
  parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSync,
  input  logic        lineSync,
  input  logic        pixValid,
  output vsbStrobes_t strobes
);

  localparam logic POL = SYNC_ACTIVE_LOW;

  logic frameAct, lineAct;
  logic framePrev, linePrev;
  logic sofPending, holdValid;
  logic frameRise, lineEnd;

  // Normalise polarity so everything below is active-high
  assign frameAct  = frameSync ^ POL;
  assign lineAct   = lineSync ^ POL;
  assign frameRise = frameAct & ~framePrev;
  assign lineEnd   = linePrev & ~lineAct;

  always_comb begin
    strobes.loadHold = pixValid & lineAct;
    strobes.holdSof  = sofPending | frameRise;
    strobes.pushHold = holdValid & ((pixValid & lineAct) | lineEnd);
    strobes.pushEol  = lineEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      framePrev  <= 1'b0;
      linePrev   <= 1'b0;
      sofPending <= 1'b0;
      holdValid  <= 1'b0;
    end else begin
      framePrev <= frameAct;
      linePrev  <= lineAct;
      if (strobes.loadHold)      sofPending <= 1'b0;
      else if (frameRise)        sofPending <= 1'b1;
      if (strobes.loadHold)      holdValid  <= 1'b1;
      else if (lineEnd)          holdValid  <= 1'b0;
    end
  end

  // R4
  sof_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameRise && !(pixValid && lineAct) |=> sofPending);

  // R3
  line_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> !holdValid);

endmodule

// File: rtl/vsb_datapath.sv
module vsb_datapath
  import vsb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  vsbStrobes_t       strobes,
  input  logic [DATA_W-1:0] pixData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outSof,
  output logic              outEol,
  output logic              overflow
);

  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int ENTRY_W = DATA_W + 2;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [DATA_W-1:0]  holdData;
  logic               holdSofR;
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               fifoFull, doWrite, doRead;
  logic [ENTRY_W-1:0] headEntry;

  assign fifoFull  = (count == FULL_CNT);
  assign doWrite   = strobes.pushHold & ~fifoFull;
  assign doRead    = outValid & outReady;
  assign headEntry = mem[rdPtr];

  assign outValid = (count != '0);
  assign outData  = headEntry[ENTRY_W-1:2];
  assign outSof   = headEntry[1];
  assign outEol   = headEntry[0];

  // Holding stage: one pixel of lookahead for the end-of-line decision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0;
      holdSofR <= 1'b0;
    end else if (strobes.loadHold) begin
      holdData <= pixData;
      holdSofR <= strobes.holdSof;
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= {holdData, holdSofR, strobes.pushEol};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doRead)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doWrite, doRead})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobes.pushHold && fifoFull) overflow <= 1'b1;
    end
  end

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushHold && fifoFull |=> overflow);

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R6
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSof) && $stable(outEol));

endmodule

// File: rtl/vidstream_bridge.sv
module vidstream_bridge
  import vsb_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int FIFO_DEPTH      = 4,
  parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixValid,
  input  logic              frameSync,
  input  logic              lineSync,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outSof,
  output logic              outEol,
  output logic              overflow
);

  vsbStrobes_t strobes;

  vsb_ctrl #(
    .SYNC_ACTIVE_LOW(SYNC_ACTIVE_LOW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameSync(frameSync),
    .lineSync (lineSync),
    .pixValid (pixValid),
    .strobes  (strobes)
  );

  vsb_datapath #(
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pixData (pixData),
    .outData (outData),
    .outValid(outValid),
    .outReady(outReady),
    .outSof  (outSof),
    .outEol  (outEol),
    .overflow(overflow)
  );

endmodule

// File: tb/vidstream_bridge_bench.sv
module vidstream_bridge_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pixData = '0;
  logic       pixValid = 1'b0, fv = 1'b0, lv = 1'b0;
  logic       outReady = 1'b0;
  logic [7:0] outData, outDataLo;
  logic       outValid, outSof, outEol, overflow;
  logic       outValidLo, outSofLo, outEolLo, overflowLo;

  int errors = 0;
  int total = 0;
  int mismatches = 0;
  int compared = 0;
  bit logging = 1'b0;
  bit comparing = 1'b0;
  logic [9:0] capBeat [32];
  int capN = 0;

  always #5 clk = ~clk;

  vidstream_bridge #(.DATA_W(8), .FIFO_DEPTH(4), .SYNC_ACTIVE_LOW(1'b0)) u_vidstream_bridge (
    .clk(clk), .rstN(rstN), .pixData(pixData), .pixValid(pixValid),
    .frameSync(fv), .lineSync(lv), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outSof(outSof), .outEol(outEol), .overflow(overflow));

  vidstream_bridge #(.DATA_W(8), .FIFO_DEPTH(4), .SYNC_ACTIVE_LOW(1'b1)) u_vidstream_bridge_lo (
    .clk(clk), .rstN(rstN), .pixData(pixData), .pixValid(pixValid),
    .frameSync(~fv), .lineSync(~lv), .outData(outDataLo), .outValid(outValidLo),
    .outReady(outReady), .outSof(outSofLo), .outEol(outEolLo), .overflow(overflowLo));

  // Stimulus {frame, line, pixValid, data[7:0]}
  localparam logic [10:0] STIM [18] = '{
    11'h000, 11'h400, 11'h5AA, 11'h710, 11'h6EE, 11'h711, 11'h712, 11'h400, 11'h400,
    11'h720, 11'h5BB, 11'h600, 11'h400, 11'h000, 11'h730, 11'h731, 11'h400, 11'h000};
  // Expected beats {data[7:0], sof, eol}
  localparam logic [9:0] EXPB [6] = '{10'h042, 10'h044, 10'h049, 10'h081, 10'h0C2, 10'h0C5};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic l, input logic p, input logic [7:0] d);
    @(posedge clk);
    #1;
    fv = f; lv = l; pixValid = p; pixData = d;
  endtask

  task automatic expectBeat(input logic [7:0] d, input logic s, input logic e, input string tag);
    @(negedge clk);
    chk(outValid === 1'b1, tag, "beat valid", 32'(outValid), 32'd1);
    chk({outData, outSof, outEol} === {d, s, e}, tag, "beat {data,sof,eol}",
        32'({outData, outSof, outEol}), 32'({d, s, e}));
  endtask

  always @(negedge clk) begin
    if (logging && outValid && outReady && capN < 32) begin
      capBeat[capN] = {outData, outSof, outEol};
      capN++;
    end
    if (comparing) begin
      compared++;
      if (outValid !== outValidLo || overflow !== overflowLo ||
          (outValid && {outData, outSof, outEol} !== {outDataLo, outSofLo, outEolLo}))
        mismatches++;
    end
  end

  initial begin
    #2_000_000;
    errors++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 / R9: state during reset
    chk(outValid === 1'b0, "R1", "outValid in reset", 32'(outValid), 0);
    chk(overflow === 1'b0, "R1", "overflow in reset", 32'(overflow), 0);
    @(posedge clk); #1 rstN = 1'b1;
    comparing = 1'b1;
    @(negedge clk);
    chk(outValid === 1'b0, "R9", "outValid after reset", 32'(outValid), 0);

    // Table walk: R2 R3 R4 R5
    outReady = 1'b1;
    logging = 1'b1;
    for (int i = 0; i < 18; i++) step(STIM[i][10], STIM[i][9], STIM[i][8], STIM[i][7:0]);
    repeat (4) step(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    logging = 1'b0;
    chk(capN == 6, "R2", "beat count", 32'(capN), 32'd6);
    for (int i = 0; i < 6; i++)
      chk(capBeat[i] === EXPB[i], "R2/R3/R4/R5", "table beat", 32'(capBeat[i]), 32'(EXPB[i]));

    // R6: stalled output holds
    outReady = 1'b0;
    step(1'b1, 1'b1, 1'b1, 8'h50);
    step(1'b1, 1'b1, 1'b1, 8'h51);
    step(1'b1, 1'b1, 1'b1, 8'h52);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk(outValid === 1'b1 && outData === 8'h50, "R6", "stalled head", 32'(outData), 32'h50);
    repeat (3) @(negedge clk);
    chk(outValid === 1'b1 && outData === 8'h50 && outSof === 1'b1, "R6", "head held",
        32'(outData), 32'h50);
    @(posedge clk); #1 outReady = 1'b1;
    expectBeat(8'h50, 1'b1, 1'b0, "R6");
    expectBeat(8'h51, 1'b0, 1'b0, "R6");
    expectBeat(8'h52, 1'b0, 1'b1, "R6");
    @(negedge clk);
    chk(outValid === 1'b0, "R9", "drained", 32'(outValid), 0);

    // R6: lookahead latency
    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b1, 1'b1, 8'h60);
    step(1'b1, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    chk(outValid === 1'b0, "R6", "pixel waits for line end", 32'(outValid), 0);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    expectBeat(8'h60, 1'b1, 1'b1, "R6");

    // R7: overflow on a stalled six-pixel line
    @(posedge clk); #1 outReady = 1'b0;
    step(1'b0, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, 8'(8'h40 + k));
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk(overflow === 1'b1, "R7", "overflow set", 32'(overflow), 1);
    @(posedge clk); #1 outReady = 1'b1;
    expectBeat(8'h40, 1'b1, 1'b0, "R7");
    expectBeat(8'h41, 1'b0, 1'b0, "R7");
    expectBeat(8'h42, 1'b0, 1'b0, "R7");
    expectBeat(8'h43, 1'b0, 1'b0, "R7");
    @(negedge clk);
    chk(outValid === 1'b0, "R7", "dropped pixels absent", 32'(outValid), 0);
    repeat (3) @(negedge clk);
    chk(overflow === 1'b1, "R7", "overflow sticky", 32'(overflow), 1);

    // R8: active-low build tracked the active-high build throughout
    comparing = 1'b0;
    chk(mismatches == 0 && compared > 50, "R8", "polarity mismatches", 32'(mismatches), 0);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule